// File: doc/BRIEF.md
# Zero-Cross Gated Stereo Volume Controller

This block keeps one 7-bit attenuation code for each of two audio channels and scales a stream of signed samples by the gain that code selects. Codes arrive on a one-cycle register-write port. Each write carries a channel select, a copy-to-both flag and a zero-cross gating flag. An ungated write takes effect on the next clock. A gated write is parked as a pending code. It becomes the active code only when that channel's own sample stream passes through zero. There is no timeout on that wait, so a constant input can hold a parked code back indefinitely. Another write of the code with gating off forces it through.

Each channel runs a two-state machine. In `CH_SETTLED` no code is waiting. In `CH_ARMED` a pending code waits for a crossing. The transitions are:
- `ARM`: a gated write moves `CH_SETTLED` or `CH_ARMED` to `CH_ARMED`.
- `FORCE`: an ungated write moves either state to `CH_SETTLED` and loads the active code.
- `CROSS`: a crossing sample with no write in the same cycle moves `CH_ARMED` to `CH_SETTLED` and promotes the pending code.
- `HOLD`: in any other cycle the state is kept.

The code maps to gain in 1 dB steps. Code 121 is unity gain, code 127 is about +6 dB and code 48 is -73 dB. Every code below 48 mutes the channel. The scaled sample is saturated to the sample width.

Top module: `zc_stereo_volume`

## Requirements
- R1: After reset both active codes are 0, both mute flags are 1, both output samples are 0 and `out_valid` is 0.
- R2: A write with `wr_zc`=0 and `wr_mirror`=0 loads `wr_code` into the channel chosen by `wr_sel` (0 = left, 1 = right). The new code is visible on `vol_l`/`vol_r` at the next clock. The other channel is unchanged.
- R3: A write with `wr_mirror`=1 loads the same code into both channels, whatever `wr_sel` is.
- R4: A write with `wr_zc`=1 leaves the active code unchanged and parks the code. The parked code becomes active at the clock that accepts the channel's next crossing sample. A crossing sample is an `in_valid` sample that equals zero, or whose sign bit differs from the sign bit of that channel's previous valid sample. The previous sign is non-negative after reset.
- R5: A parked code has no timeout. Valid samples that are nonzero and keep the same sign never apply it.
- R6: An ungated write applies its code at once, even while another code is parked. It also discards the parked code, so a later crossing changes nothing.
- R7: A newer write to a channel replaces its parked code, so only the latest code is applied. A gated write in the same cycle as a crossing sample wins: that crossing is not used, and the new code waits for a later crossing.
- R8: `mute_l`/`mute_r` is 1 exactly when that channel's active code is below 48.
- R9: `out_valid` follows `in_valid` by one clock. The output is floor(sample × 10^((code−121)/20)) within 2 LSB plus 0.2 %. Here code is the active code before any update in the clock that accepts the sample.
- R10: Results beyond the sample range saturate to 32767 or −32768.
- R11: A sample taken while the channel is muted gives an output of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Target channel: 0 left, 1 right |
| wr_code | input | 7 | Volume code |
| wr_mirror | input | 1 | Write the code to both channels |
| wr_zc | input | 1 | Wait for a zero crossing before applying |
| in_valid | input | 1 | Sample pair strobe |
| in_l | input | SMP_W | Left signed sample |
| in_r | input | SMP_W | Right signed sample |
| out_valid | output | 1 | Scaled pair valid |
| out_l | output | SMP_W | Left scaled sample |
| out_r | output | SMP_W | Right scaled sample |
| vol_l | output | 7 | Left active code |
| vol_r | output | 7 | Right active code |
| mute_l | output | 1 | Left muted |
| mute_r | output | 1 | Right muted |

## Verification
Two things can fall in the same clock: a gated write arriving on a channel, and a crossing sample arriving on that channel while it is armed. The bench provokes this by raising `wr_en` with `wr_zc`=1 in the very cycle that a sign-flipping sample is presented. It then checks that the old code stays active after that cycle, and that the new code only appears after the following crossing.

// File: rtl/zcv_pkg.sv
package zcv_pkg;
    localparam int CODE_W    = 7;
    localparam int GAIN_W    = 17;   // unsigned, 15 fraction bits
    localparam int FRAC_W    = 15;
    localparam int MUTE_CODE = 48;
    localparam int N_CODES   = 2 ** CODE_W;

    typedef enum logic {CH_SETTLED, CH_ARMED} ch_state_e;
    typedef logic [GAIN_W-1:0] gain_lut_t [N_CODES];

    // Walk down from +6 dB, multiplying by 10^(-1/20) each step.
    function automatic gain_lut_t build_gain_lut();
        gain_lut_t t;
        longint unsigned acc;
        acc = 64'd65381 << 24;
        for (int c = N_CODES - 1; c >= 0; c--) begin
            t[c] = (c < MUTE_CODE) ? '0 : GAIN_W'((acc + (64'd1 << 23)) >> 24);
            acc  = (acc * 64'd58409) >> 16;
        end
        return t;
    endfunction
endpackage

// File: rtl/zcv_channel.sv
module zcv_channel
    import zcv_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_hit,
    input  logic [CODE_W-1:0]       wr_code,
    input  logic                    wr_zc,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp,
    output logic [CODE_W-1:0]       active_code
);
    ch_state_e         state_q, state_d;
    logic [CODE_W-1:0] act_q, act_d, pend_q, pend_d;
    logic              neg_q;
    logic              crossing;

    assign crossing = smp_valid && ((smp == '0) || (smp[SMP_W-1] != neg_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_SETTLED;
            act_q   <= '0;
            pend_q  <= '0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            act_q   <= act_d;
            pend_q  <= pend_d;
            if (smp_valid) neg_q <= smp[SMP_W-1];
        end
    end

    always_comb begin
        state_d = state_q;
        act_d   = act_q;
        pend_d  = pend_q;
        if (wr_hit) begin
            if (wr_zc) begin
                state_d = CH_ARMED;
                pend_d  = wr_code;
            end else begin
                state_d = CH_SETTLED;
                act_d   = wr_code;
            end
        end else begin
            unique case (state_q)
                CH_SETTLED: ;
                CH_ARMED: if (crossing) begin
                    state_d = CH_SETTLED;
                    act_d   = pend_q;
                end
            endcase
        end
    end

    assign active_code = act_q;

    assert_force_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !wr_zc) |=> (active_code == $past(wr_code)));
    assert_gated_write_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_zc) |=> $stable(active_code) && state_q == CH_ARMED);
    assert_cross_applies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && crossing && !wr_hit) |=> (active_code == $past(pend_q)));
    assert_no_timeout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED && !crossing && !wr_hit) |=> $stable(active_code) && state_q == CH_ARMED);
endmodule

// File: rtl/zcv_scaler.sv
module zcv_scaler
    import zcv_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [CODE_W-1:0]       code,
    output logic signed [SMP_W-1:0] out_smp
);
    localparam int PROD_W = SMP_W + GAIN_W + 1;
    localparam gain_lut_t GAIN_LUT = build_gain_lut();
    localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((2 ** (SMP_W - 1)) - 1);
    localparam logic signed [PROD_W-1:0] SAT_LO = -PROD_W'(2 ** (SMP_W - 1));

    logic signed [PROD_W-1:0] prod, shifted;
    logic signed [SMP_W-1:0]  sat;

    assign prod    = PROD_W'(smp) * $signed({1'b0, GAIN_LUT[code]});
    assign shifted = prod >>> FRAC_W;

    always_comb begin
        if (shifted > SAT_HI)      sat = SAT_HI[SMP_W-1:0];
        else if (shifted < SAT_LO) sat = SAT_LO[SMP_W-1:0];
        else                       sat = shifted[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         out_smp <= '0;
        else if (smp_valid) out_smp <= (code < CODE_W'(MUTE_CODE)) ? '0 : sat;
    end

    assert_muted_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && code < CODE_W'(MUTE_CODE)) |=> (out_smp == '0));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(out_smp));
endmodule

// File: rtl/zc_stereo_volume.sv
module zc_stereo_volume
    import zcv_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_sel,
    input  logic [CODE_W-1:0]       wr_code,
    input  logic                    wr_mirror,
    input  logic                    wr_zc,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_l,
    input  logic signed [SMP_W-1:0] in_r,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_l,
    output logic signed [SMP_W-1:0] out_r,
    output logic [CODE_W-1:0]       vol_l,
    output logic [CODE_W-1:0]       vol_r,
    output logic                    mute_l,
    output logic                    mute_r
);
    localparam int N_CH = 2;

    logic signed [SMP_W-1:0] smp_in  [N_CH];
    logic signed [SMP_W-1:0] smp_out [N_CH];
    logic [CODE_W-1:0]       code    [N_CH];

    assign smp_in[0] = in_l;
    assign smp_in[1] = in_r;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_mirror || (wr_sel == (ch == 1)));

        zcv_channel #(.SMP_W(SMP_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_hit     (hit),
            .wr_code    (wr_code),
            .wr_zc      (wr_zc),
            .smp_valid  (in_valid),
            .smp        (smp_in[ch]),
            .active_code(code[ch])
        );

        zcv_scaler #(.SMP_W(SMP_W)) u_scale (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_valid(in_valid),
            .smp      (smp_in[ch]),
            .code     (code[ch]),
            .out_smp  (smp_out[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    assign out_l  = smp_out[0];
    assign out_r  = smp_out[1];
    assign vol_l  = code[0];
    assign vol_r  = code[1];
    assign mute_l = code[0] < CODE_W'(MUTE_CODE);
    assign mute_r = code[1] < CODE_W'(MUTE_CODE);

    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_mirror_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mirror && !wr_zc) |=> (vol_l == vol_r));
endmodule

// File: tb/test_zc_stereo_volume.sv
module test_zc_stereo_volume;
    localparam int SMP_W = 16;
    localparam int NV    = 10;
    localparam logic [22:0] VEC [NV] = '{
        {7'd127,  16'sd32767}, {7'd127, -16'sd32768}, {7'd121, 16'sd12345},
        {7'd121, -16'sd7},     {7'd100,  16'sd20000}, {7'd48,  16'sd30000},
        {7'd47,   16'sd30000}, {7'd0,   -16'sd32768}, {7'd127, 16'sd10000},
        {7'd115, -16'sd30000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0, wr_mirror = 0, wr_zc = 0, in_valid = 0;
    logic [6:0] wr_code = '0;
    logic signed [SMP_W-1:0] in_l = '0, in_r = '0;
    logic out_valid, mute_l, mute_r;
    logic signed [SMP_W-1:0] out_l, out_r;
    logic [6:0] vol_l, vol_r;
    int n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    zc_stereo_volume #(.SMP_W(SMP_W)) i_zc_stereo_volume (
        .clk, .rst_n, .wr_en, .wr_sel, .wr_code, .wr_mirror, .wr_zc,
        .in_valid, .in_l, .in_r, .out_valid, .out_l, .out_r,
        .vol_l, .vol_r, .mute_l, .mute_r
    );

    function automatic int model(int code, int s);
        real g;
        int  v;
        if (code < 48) return 0;
        g = 10.0 ** ((code - 121) / 20.0);
        v = $rtoi($floor(s * g));
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    task automatic check_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_near(string tag, int act, int exp);
        int d, tol;
        d   = (act > exp) ? act - exp : exp - act;
        tol = 2 + ((exp < 0) ? -exp : exp) / 500;
        n_chk++;
        if (d > tol) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input int code, input logic mir, input logic zc);
        @(negedge clk);
        wr_en = 1; wr_sel = sel; wr_code = 7'(code); wr_mirror = mir; wr_zc = zc;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic push(input int l, input int r);
        @(negedge clk);
        in_valid = 1; in_l = SMP_W'(l); in_r = SMP_W'(r);
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1 vol_l", vol_l, 0);
        check_eq("R1 vol_r", vol_r, 0);
        check_eq("R1 mute_l", mute_l, 1);
        check_eq("R1 mute_r", mute_r, 1);
        check_eq("R1 out_l", out_l, 0);
        check_eq("R1 out_valid", out_valid, 0);
        rst_n = 1;

        // Vector walk: R3 mirror, R8 mute, R9 scaling, R10 saturation, R11 muted zero
        for (int i = 0; i < NV; i++) begin
            int c, s;
            c = int'(VEC[i][22:16]);
            s = int'($signed(VEC[i][15:0]));
            wr(1'b1, c, 1'b1, 1'b0);
            check_eq("R3 mirror vol_l", vol_l, c);
            check_eq("R3 mirror vol_r", vol_r, c);
            check_eq("R8 mute_l", mute_l, int'(c < 48));
            push(s, -s - 1);
            check_eq("R9 out_valid", out_valid, 1);
            check_near("R9/R10/R11 out_l", out_l, model(c, s));
            check_near("R9/R10/R11 out_r", out_r, model(c, -s - 1));
            @(negedge clk);
            check_eq("R9 out_valid drop", out_valid, 0);
        end

        // R2 single-channel ungated writes
        wr(1'b0, 100, 1'b0, 1'b0);
        check_eq("R2 left loaded", vol_l, 100);
        check_eq("R2 right kept", vol_r, 115);
        wr(1'b1, 110, 1'b0, 1'b0);
        check_eq("R2 right loaded", vol_r, 110);
        check_eq("R2 left kept", vol_l, 100);

        // R4 gated write waits for a crossing on the right channel
        push(1000, 1000);
        wr(1'b1, 90, 1'b0, 1'b1);
        check_eq("R4 held before crossing", vol_r, 110);
        push(-1000, 2000);
        check_eq("R4 no crossing on right", vol_r, 110);
        check_near("R4 old gain used", out_r, model(110, 2000));
        push(-1000, -500);
        check_near("R4 crossing sample uses old gain", out_r, model(110, -500));
        check_eq("R4 applied after crossing", vol_r, 90);
        check_eq("R4 left untouched", vol_l, 100);
        // R4 a zero sample also counts
        wr(1'b1, 95, 1'b0, 1'b1);
        push(-1000, 0);
        check_eq("R4 zero sample crossing", vol_r, 95);

        // R5 no timeout under a constant negative input (prev right sign now non-negative)
        push(-1000, -3000);
        wr(1'b1, 60, 1'b0, 1'b1);
        for (int k = 0; k < 20; k++) push(-1000, -3000);
        check_eq("R5 DC blocks update", vol_r, 95);

        // R6 ungated write forces through and discards the parked code
        wr(1'b1, 75, 1'b0, 1'b0);
        check_eq("R6 forced", vol_r, 75);
        push(-1000, 3000);
        check_eq("R6 parked code discarded", vol_r, 75);

        // R7 newest parked code wins; same-cycle write beats crossing
        push(1000, 3000);
        wr(1'b0, 80, 1'b0, 1'b1);
        wr(1'b0, 85, 1'b0, 1'b1);
        check_eq("R7 still old", vol_l, 100);
        push(-1000, 3000);
        check_eq("R7 latest code applied", vol_l, 85);
        @(negedge clk);
        wr_en = 1; wr_sel = 0; wr_code = 7'd50; wr_mirror = 0; wr_zc = 1;
        in_valid = 1; in_l = 16'sd1000; in_r = 16'sd3000;
        @(negedge clk);
        wr_en = 0; in_valid = 0;
        check_eq("R7 collision keeps old code", vol_l, 85);
        push(-1000, 3000);
        check_eq("R7 applied on later crossing", vol_l, 50);

        // R8 mute boundary
        wr(1'b0, 47, 1'b0, 1'b0);
        check_eq("R8 code 47 muted", mute_l, 1);
        wr(1'b0, 48, 1'b0, 1'b0);
        check_eq("R8 code 48 audible", mute_l, 0);
        check_eq("R8 right audible", mute_r, 0);

        finish_run();
    end
endmodule